// File: doc/BRIEF.md
# Oscillator Loss Detector with Clock Fallback

This block supervises the main oscillator using a free-running backup clock that does not depend on it. Oscillator edges are turned into level changes by a toggle flop in the oscillator domain, carried into the backup domain through a short synchronizer, and timed there. If the backup domain counts too many cycles in a row without seeing a change, the oscillator is declared lost. The block then raises a one-cycle interrupt and moves the CPU clock onto the backup source. The fallback is permanent until the next hardware reset, even if the oscillator later recovers.

The CPU clock choice is given as a select line and a clock-enable in the backup domain, so the clock tree can gate between sources without glitches. In direct mode every backup cycle is enabled. In half-rate mode every second backup cycle is enabled. A monitor-disable bit is captured once, on the first backup clock edge after reset release. After an external reset it takes the inverse of a strap pin. After an internal reset it is cleared. While it is set, the block never fails over and never interrupts.

Top module: `osc_loss_fallback`

## Requirements
- R1: While `rst_ni` is low, `fail_o`, `irq_o`, `clk_sel_o`, `bak_ce_o` and `mon_dis_o` are all 0.
- R2: On the first `bak_clk_i` rising edge after reset release, `mon_dis_o` becomes `ext_rst_i & ~strap_i` and then holds that value until the next reset. With `ext_rst_i`=0 it is 0 whatever the strap level.
- R3: With monitoring enabled, `fail_o` goes to 1 on the sixteenth consecutive monitored backup cycle in which no oscillator toggle is seen. A toggle is visible in the backup domain two edges after it is first sampled. A running oscillator never causes a failure.
- R4: `irq_o` is high for exactly one backup cycle, in the same cycle in which `fail_o` first becomes 1.
- R5: Once set, `fail_o` stays 1 until `rst_ni` is asserted, even if oscillator edges come back.
- R6: `clk_sel_o` is 1 (backup source) exactly when `fail_o` is 1, and 0 (oscillator) otherwise.
- R7: With `half_i`=0 (direct mode) and `fail_o`=1, `bak_ce_o` is 1 on every backup cycle.
- R8: With `half_i`=1 (half-rate mode) and `fail_o`=1, `bak_ce_o` is 1 on even cycles counted from the first fail cycle (cycle 0) and 0 on odd cycles.
- R9: When `mon_dis_o` is 1, a stopped oscillator never sets `fail_o` or `irq_o`, and `bak_ce_o` stays 0.
- R10: `bak_ce_o` is 0 whenever `fail_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Supervised oscillator clock |
| bak_clk_i | input | 1 | Independent backup clock, the time base of the monitor |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| ext_rst_i | input | 1 | 1 when the current reset came from outside the chip |
| strap_i | input | 1 | Strap pin; its inverse sets the disable bit after an external reset |
| half_i | input | 1 | 0 = backup clock used undivided, 1 = divided by two |
| clk_sel_o | output | 1 | CPU clock source: 0 oscillator, 1 backup |
| bak_ce_o | output | 1 | CPU clock-enable in the backup domain |
| irq_o | output | 1 | One-cycle oscillator-loss interrupt |
| fail_o | output | 1 | Sticky oscillator-failed status |
| mon_dis_o | output | 1 | Monitor-disable bit |

## Verification
A miss counter that is off by one moves the rise of `fail_o` and `irq_o` by a single backup cycle. A comparison in every cycle against a timing model of the missing-edge run exposes this at the first failover. A divider phase that is wrong shows up as an inverted `bak_ce_o` pattern in the first fail cycle of half-rate mode. A strap that is captured wrongly is visible on `mon_dis_o` one cycle after reset release. If the failure does not stay set, `fail_o` drops within a cycle once the oscillator is resumed after a fail.

// File: rtl/olf_pkg.sv
package olf_pkg;
  localparam int unsigned MISS_LIMIT_DEF = 16;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int unsigned SYNC_DEPTH = olf_pkg::SYNC_DEPTH_DEF
) (
  input  logic osc_clk_i,
  input  logic bak_clk_i,
  input  logic rst_ni,
  output logic edge_o
);
  localparam int unsigned TAPS = SYNC_DEPTH + 1;

  logic            tog_q;
  logic [TAPS-1:0] sync_q;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  // bit 0 is the first synchronizer stage; the extra top tap is for change detect
  always_ff @(posedge bak_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[TAPS-2:0], tog_q};
  end

  assign edge_o = sync_q[TAPS-1] ^ sync_q[TAPS-2];
endmodule

// File: rtl/loss_timer.sv
module loss_timer #(
  parameter int unsigned MISS_LIMIT = olf_pkg::MISS_LIMIT_DEF
) (
  input  logic bak_clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic edge_i,
  output logic fail_o,
  output logic irq_o
);
  localparam int unsigned CNT_W = $clog2(MISS_LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fail_q, irq_q, trip;

  assign trip = active_i & ~edge_i & ~fail_q & (cnt_q == LAST);

  always_ff @(posedge bak_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (!active_i || edge_i)  cnt_q <= '0;
      else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
      if (trip) fail_q <= 1'b1;
      irq_q <= trip;
    end
  end

  assign fail_o = fail_q;
  assign irq_o  = irq_q;

  p_trip_at_limit_r3: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> $past(cnt_q) == LAST);
  p_edge_restarts_r3: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    edge_i |=> cnt_q == '0);
  p_fail_sticky_r5: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    fail_q |=> fail_q);
  p_irq_with_fail_r4: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> irq_q);
  p_irq_single_r4: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/clk_fallback_sel.sv
module clk_fallback_sel (
  input  logic bak_clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic half_i,
  output logic sel_o,
  output logic ce_o
);
  logic div_q;

  // phase is primed to 1 so the first fail cycle is always enabled
  always_ff @(posedge bak_clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= 1'b1;
    else if (!fail_i) div_q <= 1'b1;
    else              div_q <= ~div_q;
  end

  assign sel_o = fail_i;
  assign ce_o  = fail_i & (~half_i | div_q);

  p_half_gap_r8: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    (fail_i && half_i && ce_o) |=> (!half_i || !ce_o));
  p_half_refill_r8: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    (fail_i && half_i && !ce_o) |=> (!half_i || ce_o));
endmodule

// File: rtl/osc_loss_fallback.sv
module osc_loss_fallback #(
  parameter int unsigned MISS_LIMIT = olf_pkg::MISS_LIMIT_DEF,
  parameter int unsigned SYNC_DEPTH = olf_pkg::SYNC_DEPTH_DEF
) (
  input  logic osc_clk_i,
  input  logic bak_clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic strap_i,
  input  logic half_i,
  output logic clk_sel_o,
  output logic bak_ce_o,
  output logic irq_o,
  output logic fail_o,
  output logic mon_dis_o
);
  logic init_q, dis_q, active, osc_edge;

  // disable bit is latched once, on the first backup edge after reset release
  always_ff @(posedge bak_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      dis_q  <= 1'b0;
    end else if (init_q) begin
      init_q <= 1'b0;
      dis_q  <= ext_rst_i & ~strap_i;
    end
  end

  assign active = ~init_q & ~dis_q;

  osc_edge_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .osc_clk_i (osc_clk_i),
    .bak_clk_i (bak_clk_i),
    .rst_ni    (rst_ni),
    .edge_o    (osc_edge)
  );

  loss_timer #(.MISS_LIMIT(MISS_LIMIT)) u_timer (
    .bak_clk_i (bak_clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .edge_i    (osc_edge),
    .fail_o    (fail_o),
    .irq_o     (irq_o)
  );

  clk_fallback_sel u_sel (
    .bak_clk_i (bak_clk_i),
    .rst_ni    (rst_ni),
    .fail_i    (fail_o),
    .half_i    (half_i),
    .sel_o     (clk_sel_o),
    .ce_o      (bak_ce_o)
  );

  assign mon_dis_o = dis_q;

  p_dis_frozen_r2: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    !init_q |=> $stable(dis_q));
  p_dis_blocks_fail_r9: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    dis_q |-> !fail_o && !irq_o);
  p_no_fail_in_init_r3: assert property (@(posedge bak_clk_i) disable iff (!rst_ni)
    init_q |-> !fail_o);
endmodule

// File: tb/osc_loss_fallback_test.sv
module osc_loss_fallback_test;
  localparam int BAK_PERIOD = 10;
  localparam int OSC_HALF   = 15;
  localparam int LIMIT      = 16;

  logic osc = 1'b0, bak = 1'b0, rst_n = 1'b0;
  logic ext = 1'b0, strap = 1'b0, half = 1'b0, osc_run = 1'b0;
  logic clk_sel, ce, irq, fail, dis;
  int total = 0, bad = 0;
  bit done = 1'b0;

  osc_loss_fallback uut (
    .osc_clk_i (osc), .bak_clk_i (bak), .rst_ni (rst_n),
    .ext_rst_i (ext), .strap_i (strap), .half_i (half),
    .clk_sel_o (clk_sel), .bak_ce_o (ce), .irq_o (irq),
    .fail_o (fail), .mon_dis_o (dis)
  );

  initial forever #(BAK_PERIOD/2) bak = ~bak;
  // oscillator edges land at times 2 or 7 mod 10, never on a backup edge
  initial begin
    #2;
    forever begin
      #OSC_HALF;
      if (osc_run) osc = ~osc;
    end
  end

  bit osc_par;
  always @(posedge osc or negedge rst_n)
    if (!rst_n) osc_par <= 1'b0; else osc_par <= ~osc_par;

  // reference model
  bit m_init, m_dis, m_fail, m_irq;
  int m_run, m_phase;
  bit hist[$];
  always @(posedge bak or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 1; m_dis = 0; m_fail = 0; m_irq = 0; m_run = 0; m_phase = 0;
      hist = '{0, 0, 0};
    end else begin
      bit seen;
      seen = hist[1] != hist[2];
      m_irq = 0;
      if (m_fail) m_phase++;
      if (m_init) begin
        m_init = 0; m_dis = ext & ~strap; m_run = 0;
      end else if (m_dis || seen) begin
        m_run = 0;
      end else if (!m_fail) begin
        m_run++;
        if (m_run == LIMIT) begin m_fail = 1; m_irq = 1; m_phase = 0; end
      end
      hist.push_front(osc_par);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge bak) if (rst_n && !done) begin
    bit exp_ce;
    exp_ce = m_fail && (!half || (m_phase % 2 == 0));
    check(fail == m_fail, m_fail ? "R5" : "R3", fail, m_fail);
    check(irq == m_irq, "R4", irq, m_irq);
    check(clk_sel == m_fail, "R6", clk_sel, m_fail);
    check(ce == exp_ce, !m_fail ? "R10" : (half ? "R8" : "R7"), ce, exp_ce);
    check(dis == m_dis, "R2", dis, m_dis);
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge bak);
  endtask

  task automatic do_reset(input bit e, input bit s);
    @(negedge bak);
    rst_n = 1'b0; ext = e; strap = s;
    cycles(3);
    check(!fail && !irq && !clk_sel && !ce && !dis, "R1",
          {fail, irq, clk_sel, ce, dis}, 0);
    rst_n = 1'b1;
    cycles(2);
  endtask

  initial begin
    #(BAK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // internal reset: strap ignored, monitor enabled
    osc_run = 1'b1; half = 1'b0;
    do_reset(1'b0, 1'b0);
    check(dis == 1'b0, "R2", dis, 0);
    cycles(100);
    check(fail == 1'b0, "R3", fail, 0);
    osc_run = 1'b0; cycles(8); osc_run = 1'b1;   // short gap, below limit
    cycles(40);
    check(fail == 1'b0, "R3", fail, 0);
    osc_run = 1'b0;
    cycles(40);
    check(fail == 1'b1, "R3", fail, 1);
    check(ce == 1'b1, "R7", ce, 1);
    half = 1'b1; cycles(11);
    half = 1'b0; cycles(5);
    osc_run = 1'b1; cycles(40);
    check(fail == 1'b1 && clk_sel == 1'b1, "R5", {fail, clk_sel}, 3);

    // external reset, strap low -> monitor disabled
    osc_run = 1'b0;
    do_reset(1'b1, 1'b0);
    check(dis == 1'b1, "R2", dis, 1);
    cycles(60);
    check(fail == 1'b0 && irq == 1'b0 && ce == 1'b0, "R9", {fail, irq, ce}, 0);

    // external reset, strap high -> enabled, stopped oscillator, half rate
    half = 1'b1;
    do_reset(1'b1, 1'b1);
    check(dis == 1'b0, "R2", dis, 0);
    cycles(40);
    check(fail == 1'b1, "R3", fail, 1);
    cycles(7);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule